// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This block shifts every lane of a 32-bit packed word in one operation. The lanes are either four 8-bit elements or two 16-bit elements. Three shift kinds are available: arithmetic right, logical right and logical left. The distance is taken either from the low bits of a second register operand or from a 4-bit immediate.

A 2-bit mode field picks a variant. In the plain mode every lane is shifted normally. In the variant mode a right shift rounds to nearest and a left shift saturates at the signed lane limits. The lane width is not a separate field. It follows from the register indices of the operation: every index in the narrow band gives 8-bit lanes, and every index in the wide band gives 16-bit lanes.

Encodings that cannot be served raise an illegal flag and return zero. The result, the saturation flag and the illegal flag are registered and appear one cycle after the input strobe.

Top module: `simd_shift_unit`

## Requirements
- R1: Lane width comes from the indices. If rdIdx, rs1Idx and rs2Idx all lie in 2..15, the word is four 8-bit lanes. If all three lie in 16..29, it is two 16-bit lanes. In immediate form (useImm=1) rs2Idx is ignored.
- R2: opSel encodes the shift kind: 00 is arithmetic right, 01 is logical right and 10 is logical left. With mode 00 each lane is shifted independently, and the bits shifted out are lost.
- R3: The distance is immAmt when useImm=1, otherwise rs2Data[3:0]. For 16-bit lanes all 4 bits are used. For 8-bit lanes only the low 3 bits are used.
- R4: With mode 01 on either right shift, each lane gets the truncated result plus the last bit shifted out (bit s-1 of the lane input), kept in lane width.
- R5: A distance of zero returns every lane unchanged, for every legal kind and mode. In particular, no rounding increment is added.
- R6: With mode 01 on a left shift, lanes are treated as signed. A lane whose shifted value does not fit is replaced by the signed maximum (non-negative input) or the signed minimum (negative input).
- R7: satFlag is 1 only when the capture was a mode-01 left shift and at least one lane clamped. Otherwise it is 0.
- R8: The capture is illegal, with illegalFlag=1, outData=0 and satFlag=0, in any of these cases: the used indices fall in different bands; any used index is 0, 1, 30 or 31; mode is 10 or 11; or opSel is 11.
- R9: outValid is high exactly in the cycle after inValid. outData, satFlag and illegalFlag change only in a cycle that follows inValid.
- R10: After reset, outValid, outData, satFlag and illegalFlag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operation strobe |
| opSel | input | 2 | Shift kind |
| mode | input | 2 | 00 plain, 01 round/saturate |
| useImm | input | 1 | Take distance from immAmt |
| rdIdx | input | 5 | Destination register index |
| rs1Idx | input | 5 | Source register index |
| rs2Idx | input | 5 | Distance register index |
| rs1Data | input | 32 | Packed word to shift |
| rs2Data | input | 32 | Distance operand (low bits used) |
| immAmt | input | 4 | Immediate distance |
| outValid | output | 1 | Result valid |
| outData | output | 32 | Shifted packed word |
| satFlag | output | 1 | A lane clamped |
| illegalFlag | output | 1 | Encoding rejected |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing, that outputs hold between strobes, that an illegal capture gives zero data with no saturation, that a zero distance passes the word through, and that the saturation flag stays low outside the saturating mode. Whether each lane's rounding increment and clamp value are arithmetically right, and whether the index bands and distance masking choose the right lane width, can only be shown by the bench. The bench compares directed corner cases and seeded random operations against its own lane-by-lane model.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

  localparam int AMT_W = 4;

  typedef enum logic [1:0] {
    SH_SRA  = 2'd0,
    SH_SRL  = 2'd1,
    SH_SLL  = 2'd2,
    SH_NONE = 2'd3
  } shiftKind_e;

  typedef enum logic [1:0] {
    IDX_NARROW = 2'd0,
    IDX_WIDE   = 2'd1,
    IDX_BAD    = 2'd2
  } idxClass_e;

  typedef struct packed {
    logic             load;
    logic             illegal;
    logic             laneIs8;
    shiftKind_e       kind;
    logic             roundEn;
    logic             satEn;
    logic [AMT_W-1:0] amt;
  } shiftCtrl_t;

  function automatic idxClass_e classifyIdx(input logic [4:0] idx);
    if (idx >= 5'd2 && idx <= 5'd15)       return IDX_NARROW;
    else if (idx >= 5'd16 && idx <= 5'd29) return IDX_WIDE;
    else                                   return IDX_BAD;
  endfunction

endpackage

// File: rtl/simd_shift_lane.sv
module simd_shift_lane
  import simd_shift_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  laneIn,
  input  logic [AW-1:0] amt,
  input  shiftKind_e    kind,
  input  logic          roundEn,
  input  logic          satEn,
  output logic [W-1:0]  laneOut,
  output logic          laneSat
);

  logic [W-1:0]  truncSra;
  logic [W-1:0]  truncSrl;
  logic [W-1:0]  shl;
  logic [W-1:0]  back;
  logic [W-1:0]  clampVal;
  logic [AW-1:0] amtLess;
  logic          roundBit;
  logic          lost;

  always_comb begin
    truncSra = W'($signed(laneIn) >>> amt);
    truncSrl = laneIn >> amt;
    amtLess  = amt - AW'(1);
    roundBit = (amt != '0) ? laneIn[amtLess] : 1'b0;
    shl      = laneIn << amt;
    back     = W'($signed(shl) >>> amt);
    lost     = (back != laneIn);
    clampVal = laneIn[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    laneSat  = 1'b0;
    unique case (kind)
      SH_SRA:  laneOut = truncSra + ((roundEn && roundBit) ? W'(1) : W'(0));
      SH_SRL:  laneOut = truncSrl + ((roundEn && roundBit) ? W'(1) : W'(0));
      SH_SLL: begin
        if (satEn && lost) begin
          laneOut = clampVal;
          laneSat = 1'b1;
        end else begin
          laneOut = shl;
        end
      end
      default: laneOut = '0;
    endcase
  end

endmodule

// File: rtl/simd_shift_ctrl.sv
module simd_shift_ctrl
  import simd_shift_pkg::*;
(
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [1:0]       mode,
  input  logic             useImm,
  input  logic [4:0]       rdIdx,
  input  logic [4:0]       rs1Idx,
  input  logic [4:0]       rs2Idx,
  input  logic [AMT_W-1:0] regAmt,
  input  logic [AMT_W-1:0] immAmt,
  output shiftCtrl_t       ctrl
);

  idxClass_e  clsDst;
  idxClass_e  clsSrc;
  idxClass_e  clsAmt;
  shiftKind_e kindIn;
  logic       badIdx;
  logic       badOp;
  logic       badMode;
  logic       isRight;
  logic       variant;

  always_comb begin
    clsDst  = classifyIdx(rdIdx);
    clsSrc  = classifyIdx(rs1Idx);
    clsAmt  = useImm ? clsDst : classifyIdx(rs2Idx);
    badIdx  = (clsDst == IDX_BAD) || (clsSrc != clsDst) || (clsAmt != clsDst);
    kindIn  = shiftKind_e'(opSel);
    badOp   = (kindIn == SH_NONE);
    badMode = mode[1];
    isRight = (kindIn == SH_SRA) || (kindIn == SH_SRL);
    variant = (mode == 2'b01);

    ctrl.load    = inValid;
    ctrl.illegal = badIdx || badOp || badMode;
    ctrl.laneIs8 = (clsDst == IDX_NARROW);
    ctrl.kind    = kindIn;
    ctrl.roundEn = variant && isRight;
    ctrl.satEn   = variant && (kindIn == SH_SLL);
    ctrl.amt     = useImm ? immAmt : regAmt;
  end

endmodule

// File: rtl/simd_shift_dp.sv
module simd_shift_dp
  import simd_shift_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int LANE_WIDE   = 16,
  parameter int LANE_NARROW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  shiftCtrl_t      ctrl,
  input  logic [XLEN-1:0] srcWord,
  output logic            outValid,
  output logic [XLEN-1:0] outData,
  output logic            satFlag,
  output logic            illegalFlag
);

  localparam int NUM_WIDE   = XLEN / LANE_WIDE;
  localparam int NUM_NARROW = XLEN / LANE_NARROW;
  localparam int AW_WIDE    = $clog2(LANE_WIDE);
  localparam int AW_NARROW  = $clog2(LANE_NARROW);

  logic [XLEN-1:0]       wideRes;
  logic [XLEN-1:0]       narrowRes;
  logic [NUM_WIDE-1:0]   wideSat;
  logic [NUM_NARROW-1:0] narrowSat;
  logic [AW_WIDE-1:0]    amtWide;
  logic [AW_NARROW-1:0]  amtNarrow;
  logic [XLEN-1:0]       pickRes;
  logic                  pickSat;
  logic                  effZero;

  assign amtWide   = ctrl.amt[AW_WIDE-1:0];
  assign amtNarrow = ctrl.amt[AW_NARROW-1:0];

  for (genvar g = 0; g < NUM_WIDE; g++) begin : gWide
    simd_shift_lane #(.W(LANE_WIDE)) uLane (
      .laneIn  (srcWord[g*LANE_WIDE +: LANE_WIDE]),
      .amt     (amtWide),
      .kind    (ctrl.kind),
      .roundEn (ctrl.roundEn),
      .satEn   (ctrl.satEn),
      .laneOut (wideRes[g*LANE_WIDE +: LANE_WIDE]),
      .laneSat (wideSat[g])
    );
  end

  for (genvar g = 0; g < NUM_NARROW; g++) begin : gNarrow
    simd_shift_lane #(.W(LANE_NARROW)) uLane (
      .laneIn  (srcWord[g*LANE_NARROW +: LANE_NARROW]),
      .amt     (amtNarrow),
      .kind    (ctrl.kind),
      .roundEn (ctrl.roundEn),
      .satEn   (ctrl.satEn),
      .laneOut (narrowRes[g*LANE_NARROW +: LANE_NARROW]),
      .laneSat (narrowSat[g])
    );
  end

  always_comb begin
    pickRes = ctrl.laneIs8 ? narrowRes : wideRes;
    pickSat = ctrl.laneIs8 ? (|narrowSat) : (|wideSat);
    effZero = ctrl.laneIs8 ? (amtNarrow == '0) : (amtWide == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      satFlag     <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outData     <= ctrl.illegal ? '0 : pickRes;
        satFlag     <= !ctrl.illegal && pickSat;
        illegalFlag <= ctrl.illegal;
      end
    end
  end

  // R9: one-cycle strobe-to-valid latency
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> !outValid);
  // R9: results hold between strobes
  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(outData) && $stable(satFlag) && $stable(illegalFlag)));
  // R8: rejected encodings give zero and no saturation
  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.illegal) |=> (illegalFlag && !satFlag && outData == '0));
  // R5: a zero distance passes the word through
  assert_zero_amt_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.illegal && effZero) |=> (outData == $past(srcWord)));
  // R7: saturation only from the saturating left shift
  assert_sat_only_sll_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.satEn) |=> !satFlag);

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import simd_shift_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic [1:0]      mode,
  input  logic            useImm,
  input  logic [4:0]      rdIdx,
  input  logic [4:0]      rs1Idx,
  input  logic [4:0]      rs2Idx,
  input  logic [XLEN-1:0] rs1Data,
  input  logic [XLEN-1:0] rs2Data,
  input  logic [3:0]      immAmt,
  output logic            outValid,
  output logic [XLEN-1:0] outData,
  output logic            satFlag,
  output logic            illegalFlag
);

  shiftCtrl_t ctrl;

  simd_shift_ctrl uCtrl (
    .inValid (inValid),
    .opSel   (opSel),
    .mode    (mode),
    .useImm  (useImm),
    .rdIdx   (rdIdx),
    .rs1Idx  (rs1Idx),
    .rs2Idx  (rs2Idx),
    .regAmt  (rs2Data[AMT_W-1:0]),
    .immAmt  (immAmt),
    .ctrl    (ctrl)
  );

  simd_shift_dp #(.XLEN(XLEN)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .srcWord     (rs1Data),
    .outValid    (outValid),
    .outData     (outData),
    .satFlag     (satFlag),
    .illegalFlag (illegalFlag)
  );

endmodule

// File: tb/simd_shift_unit_test.sv
module simd_shift_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [1:0]  mode = '0;
  logic        useImm = 1'b0;
  logic [4:0]  rdIdx = '0;
  logic [4:0]  rs1Idx = '0;
  logic [4:0]  rs2Idx = '0;
  logic [31:0] rs1Data = '0;
  logic [31:0] rs2Data = '0;
  logic [3:0]  immAmt = '0;
  logic        outValid;
  logic [31:0] outData;
  logic        satFlag;
  logic        illegalFlag;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  simd_shift_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int bandOf(input logic [4:0] idx);
    if (idx >= 2 && idx <= 15) return 0;
    if (idx >= 16 && idx <= 29) return 1;
    return 2;
  endfunction

  // returns {illegal, sat, data}
  function automatic logic [33:0] model(input logic [1:0] op, input logic [1:0] md,
      input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2, input logic imm,
      input logic [3:0] immV, input logic [31:0] a, input logic [31:0] b);
    int bd, w, n, s;
    logic [31:0] res;
    logic sat;
    longint mask, v, sv, r, full, maxV, minV;
    bd = bandOf(rd);
    if (bd == 2 || bandOf(r1) != bd || (!imm && bandOf(r2) != bd) || md[1] || op == 2'b11)
      return {1'b1, 1'b0, 32'h0};
    w = (bd == 1) ? 16 : 8;
    n = 32 / w;
    s = int'(imm ? immV : b[3:0]) & (w - 1);
    mask = (longint'(1) << w) - 1;
    maxV = (longint'(1) << (w - 1)) - 1;
    minV = -(longint'(1) << (w - 1));
    res = '0;
    sat = 1'b0;
    for (int i = 0; i < n; i++) begin
      v  = (longint'(a) >> (i * w)) & mask;
      sv = (v > maxV) ? v - (longint'(1) << w) : v;
      if (op == 2'b10) begin
        full = sv * (longint'(1) << s);
        if (md == 2'b01 && (full > maxV || full < minV)) begin
          r = (sv < 0) ? minV : maxV;
          sat = 1'b1;
        end else r = full;
      end else begin
        r = (op == 2'b00) ? (sv >>> s) : (v >> s);
        if (md == 2'b01 && s > 0) r = r + ((v >> (s - 1)) & 1);
      end
      res = res | 32'((r & mask) << (i * w));
    end
    return {1'b0, sat, res};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, result sampled one falling edge later
  task automatic runOp(input string tag, input logic [1:0] op, input logic [1:0] md,
      input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2, input logic imm,
      input logic [3:0] immV, input logic [31:0] a, input logic [31:0] b);
    logic [33:0] e;
    e = model(op, md, rd, r1, r2, imm, immV, a, b);
    inValid = 1'b1; opSel = op; mode = md; rdIdx = rd; rs1Idx = r1; rs2Idx = r2;
    useImm = imm; immAmt = immV; rs1Data = a; rs2Data = b;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid R9"}, {31'b0, outValid}, 32'd1);
    check({tag, " data"}, outData, e[31:0]);
    check({tag, " sat R7"}, {31'b0, satFlag}, {31'b0, e[32]});
    check({tag, " illegal R8"}, {31'b0, illegalFlag}, {31'b0, e[33]});
  endtask

  task automatic litCheck(input string tag, input logic [31:0] exp, input logic expSat);
    check({tag, " literal"}, outData, exp);
    check({tag, " literal sat"}, {31'b0, satFlag}, {31'b0, expSat});
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 reset valid", {31'b0, outValid}, 32'd0);
    check("R10 reset data", outData, 32'd0);
    check("R10 reset sat", {31'b0, satFlag}, 32'd0);
    check("R10 reset illegal", {31'b0, illegalFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: arithmetic right on 8-bit lanes
    runOp("R1 R2 sra8", 2'b00, 2'b00, 5'd3, 5'd4, 5'd5, 1'b0, 4'd0, 32'h80_7F_F0_10, 32'd7);
    litCheck("R2 sra8", 32'hFF_00_FF_00, 1'b0);
    runOp("R1 R2 srl16", 2'b01, 2'b00, 5'd20, 5'd21, 5'd22, 1'b0, 4'd0, 32'h8000_F00F, 32'd4);
    litCheck("R2 srl16", 32'h0800_0F00, 1'b0);
    // R4: rounding right shifts
    runOp("R4 srl8 round", 2'b01, 2'b01, 5'd2, 5'd2, 5'd2, 1'b1, 4'd1, 32'h03_01_FF_02, 32'd0);
    litCheck("R4 srl8", 32'h02_01_80_01, 1'b0);
    runOp("R4 sra16 round", 2'b00, 2'b01, 5'd16, 5'd17, 5'd18, 1'b1, 4'd1, 32'hFFFD_0005, 32'd0);
    litCheck("R4 sra16", 32'hFFFF_0003, 1'b0);
    // R5: zero distance, no rounding
    runOp("R5 zero amt", 2'b01, 2'b01, 5'd7, 5'd8, 5'd9, 1'b0, 4'd0, 32'hDEAD_BEEF, 32'hFFFF_FFF8);
    litCheck("R5 zero amt", 32'hDEAD_BEEF, 1'b0);
    // R6/R7: saturating left shifts
    runOp("R6 sll16 sat", 2'b10, 2'b01, 5'd29, 5'd29, 5'd29, 1'b1, 4'd1, 32'h4000_C000, 32'd0);
    litCheck("R6 sll16", 32'h7FFF_8000, 1'b1);
    runOp("R6 sll8 sat", 2'b10, 2'b01, 5'd10, 5'd11, 5'd12, 1'b1, 4'd1, 32'h81_40_01_C0, 32'd0);
    litCheck("R6 sll8", 32'h80_7F_02_80, 1'b1);
    runOp("R7 sll16 plain", 2'b10, 2'b00, 5'd19, 5'd19, 5'd19, 1'b1, 4'd1, 32'h4000_0001, 32'd0);
    litCheck("R7 sll16 plain", 32'h8000_0002, 1'b0);
    // R3: distance masking and immediate form ignores rs2Idx
    runOp("R3 amt mask8", 2'b01, 2'b00, 5'd2, 5'd3, 5'd4, 1'b0, 4'd0, 32'h80_80_80_80, 32'h0000_000F);
    litCheck("R3 mask8", 32'h01_01_01_01, 1'b0);
    runOp("R3 imm ignores rs2Idx", 2'b00, 2'b00, 5'd24, 5'd25, 5'd31, 1'b1, 4'd15, 32'h8000_7FFF, 32'd0);
    litCheck("R3 imm", 32'hFFFF_0000, 1'b0);
    // R8: illegal encodings
    runOp("R8 mixed bands", 2'b00, 2'b00, 5'd5, 5'd20, 5'd6, 1'b0, 4'd0, 32'h1234_5678, 32'd1);
    runOp("R8 bad index", 2'b01, 2'b00, 5'd30, 5'd30, 5'd30, 1'b1, 4'd1, 32'h1234_5678, 32'd0);
    runOp("R8 mode 10", 2'b10, 2'b10, 5'd16, 5'd16, 5'd16, 1'b1, 4'd1, 32'h4000_4000, 32'd0);
    runOp("R8 op 11", 2'b11, 2'b00, 5'd16, 5'd16, 5'd16, 1'b1, 4'd1, 32'h1234_5678, 32'd0);
    litCheck("R8 op 11", 32'h0, 1'b0);
    // R9: no strobe, outputs hold
    runOp("R9 setup", 2'b10, 2'b01, 5'd20, 5'd20, 5'd20, 1'b1, 4'd3, 32'h7000_0123, 32'd0);
    held = outData;
    rs1Data = 32'hFFFF_FFFF; opSel = 2'b01; immAmt = 4'd2;
    @(negedge clk);
    check("R9 no valid", {31'b0, outValid}, 32'd0);
    check("R9 data held", outData, held);
    check("R9 sat held", {31'b0, satFlag}, 32'd1);

    // seeded random mix, mostly legal
    for (int k = 0; k < 400; k++) begin
      logic [4:0] ra, rb, rc;
      logic [1:0] op, md;
      int pick;
      pick = int'($urandom % 16);
      if ($urandom % 2 == 0) begin
        ra = 5'(2 + $urandom % 14); rb = 5'(2 + $urandom % 14); rc = 5'(2 + $urandom % 14);
      end else begin
        ra = 5'(16 + $urandom % 14); rb = 5'(16 + $urandom % 14); rc = 5'(16 + $urandom % 14);
      end
      if (pick == 0) rb = 5'($urandom);
      op = 2'($urandom % 3);
      md = 2'($urandom % 2);
      if (pick == 1) md = 2'($urandom);
      if (pick == 2) op = 2'($urandom);
      runOp("R1 R2 R4 R6 random", op, md, ra, rb, rc, 1'($urandom), 4'($urandom),
            $urandom, $urandom);
      if ($urandom % 4 == 0) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule